// File: doc/BRIEF.md
# Ramp Run-Down Converter Sequencer

This block controls the digital side of a ramp run-down analog-to-digital converter. When the front end reports that a pulse peak is held on the storage capacitor, the sequencer raises three control strobes on one clock edge. The first isolates the capacitor from the peak stretcher, the second switches on a constant discharge current, and the third enables a clock counter. The counter runs until the baseline comparator reports that the capacitor has discharged. The count, corrected for the comparator synchronizer latency, is the channel number. Conversion time therefore grows linearly with pulse amplitude, at one clock period per channel.

The comparator output is asynchronous and passes through a two-flop synchronizer. Its latency is a fixed offset: discharge always lasts three clock cycles longer than the reported code. If the comparator has not tripped by full scale, the result saturates at the top code and an overflow flag is set. After the stop, the current source is switched off first and the capacitor is reconnected next. Only then does busy drop and the result valid pulse appear. Peak reports that arrive while busy are rejected and tallied in a saturating lost-event counter.

Top module: `rundown_adc_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `hold_isolate`, `dischg_on`, `count_en`, `busy`, `code_valid` and `overflow` are 0, and `code` and `lost_count` are 0.
- R2: A `peak_ok` sampled high while `busy` is 0 makes `hold_isolate`, `dischg_on`, `count_en` and `busy` all rise on the same clock edge.
- R3: If `cmp_above` (1 = capacitor above baseline) goes low after exactly A clock edges with `dischg_on` high, where A ≤ 8191, then `code` is A (13 bits, binary) and `overflow` is 0. This includes A = 0.
- R4: The comparator passes through a 2-stage synchronizer, and its low level is ignored during the first two run cycles. As a result, `dischg_on` and `count_en` stay high for exactly A+3 cycles.
- R5: If `cmp_above` is still high when the count reaches full scale, the conversion ends as it would for A = 8191, but with `code` = 8191 and `overflow` = 1. A comparator trip exactly at A = 8191 gives `overflow` = 0.
- R6: At the stop, `dischg_on` and `count_en` fall first. `hold_isolate` falls one edge later. `busy` falls one edge after that, together with a one-cycle `code_valid` pulse. Busy therefore lasts A+5 cycles and `hold_isolate` lasts A+4 cycles.
- R7: Each cycle in which `peak_ok` is high while `busy` is 1 leaves the running conversion's timing and code unchanged, and increments `lost_count` by one.
- R8: `lost_count` (8 bits) saturates at 255.
- R9: `code` and `overflow` hold their values after `code_valid` falls, until the next conversion ends. A normal conversion clears a previous `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| peak_ok | input | 1 | Peak captured on the hold capacitor |
| cmp_above | input | 1 | Asynchronous comparator, 1 while capacitor is above baseline |
| hold_isolate | output | 1 | Disconnect capacitor from stretcher |
| dischg_on | output | 1 | Enable constant discharge current |
| count_en | output | 1 | Counter running |
| busy | output | 1 | Dead time, no new peak accepted |
| code | output | 13 | Channel number |
| overflow | output | 1 | Comparator did not trip by full scale |
| code_valid | output | 1 | One-cycle pulse when a result is ready |
| lost_count | output | 8 | Saturating count of rejected peaks |

## Verification
A corrupted sequencer state shows up at the strobe ports within one edge. A strobe that rises alone or falls out of order breaks the lockstep and release-order checks at the very next sample. A counter or synchronizer fault does not show until the conversion ends. It then appears as a code that differs from the bench's ramp amplitude, or as a discharge length other than A+3, and the miss is visible on the `code_valid` cycle. Amplitudes of 0, small values, exactly full scale and beyond full scale cover the blanking window and the saturation boundary.

// File: rtl/wrd_pkg.sv
`timescale 1ns/1ps
package wrd_pkg;

    localparam int DEF_CODE_W      = 13;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int DEF_LOST_W      = 8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_CUR_OFF = 2'd2,
        ST_RECON   = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic isolate;
        logic discharge;
        logic count;
        logic busy;
    } strobe_t;

    function automatic strobe_t decode_strobes(seq_state_t s);
        strobe_t r;
        r.isolate   = (s == ST_RUN) || (s == ST_CUR_OFF);
        r.discharge = (s == ST_RUN);
        r.count     = (s == ST_RUN);
        r.busy      = (s != ST_IDLE);
        return r;
    endfunction

    function automatic int count_width(int code_w, int sync_stages);
        return $clog2((1 << code_w) + sync_stages + 1);
    endfunction

endpackage

// File: rtl/wrd_sync.sv
`timescale 1ns/1ps
module wrd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

    // R4: output follows the input exactly STAGES edges later
    assert_sync_delay_R4: assert property (@(posedge clk) disable iff (rst)
        $past(rst) == 1'b0 |-> q == $past(chain[STAGES-2]));
endmodule

// File: rtl/wrd_runcounter.sv
`timescale 1ns/1ps
module wrd_runcounter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         en,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (clear) cnt <= '0;
        else if (en)    cnt <= cnt + 1'b1;
    end

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        en && !clear |=> cnt == $past(cnt) + 1'b1);

    assert_count_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !en && !clear |=> $stable(cnt));
endmodule

// File: rtl/wrd_lost.sv
`timescale 1ns/1ps
module wrd_lost #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hit,
    output logic [W-1:0] total
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)                      total <= '0;
        else if (hit && total != TOP) total <= total + 1'b1;
    end

    assert_lost_step_R7: assert property (@(posedge clk) disable iff (rst)
        hit && total != TOP |=> total == $past(total) + 1'b1);

    assert_lost_sat_R8: assert property (@(posedge clk) disable iff (rst)
        total == TOP |=> total == TOP);

    assert_lost_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(total));
endmodule

// File: rtl/wrd_fsm.sv
`timescale 1ns/1ps
module wrd_fsm
    import wrd_pkg::*;
#(
    parameter int CODE_W      = 13,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              peak,
    input  logic              cmp_s,
    input  logic [CNT_W-1:0]  cnt,
    output strobe_t           st,
    output logic              cnt_clear,
    output logic              lost_hit,
    output logic [CODE_W-1:0] code,
    output logic              ovf,
    output logic              code_valid
);
    localparam int                FULL_I = (1 << CODE_W) - 1;
    localparam logic [CNT_W-1:0]  LIMIT  = CNT_W'(FULL_I + SYNC_STAGES);
    localparam logic [CNT_W-1:0]  BLANK  = CNT_W'(SYNC_STAGES);
    localparam logic [CODE_W-1:0] FULL   = '1;

    seq_state_t state;
    logic       stop;
    logic       limit;
    logic       accept;

    assign st        = decode_strobes(state);
    assign accept    = (state == ST_IDLE) && peak;
    assign cnt_clear = accept;
    assign lost_hit  = peak && (state != ST_IDLE);
    assign stop      = (cnt >= BLANK) && !cmp_s;
    assign limit     = (cnt == LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            code       <= '0;
            ovf        <= 1'b0;
            code_valid <= 1'b0;
        end else begin
            code_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (peak) state <= ST_RUN;
                end
                ST_RUN: begin
                    if (stop) begin
                        code  <= CODE_W'(cnt - BLANK);
                        ovf   <= 1'b0;
                        state <= ST_CUR_OFF;
                    end else if (limit) begin
                        code  <= FULL;
                        ovf   <= 1'b1;
                        state <= ST_CUR_OFF;
                    end
                end
                ST_CUR_OFF: state <= ST_RECON;
                ST_RECON: begin
                    state      <= ST_IDLE;
                    code_valid <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_strobes_together_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(st.isolate) |-> $rose(st.discharge) && $rose(st.count) && $rose(st.busy));

    assert_start_from_idle_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(st.discharge) |-> !$past(st.busy));

    assert_release_order_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(st.discharge) |-> st.isolate && st.busy && !st.count);

    assert_busy_last_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(st.busy) |-> !st.isolate && code_valid);

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        code_valid |=> !code_valid);

    assert_no_overflow_code_R5: assert property (@(posedge clk) disable iff (rst)
        ovf |-> code == FULL);

    assert_result_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !$fell(st.discharge) |-> $stable(code) && $stable(ovf));
endmodule

// File: rtl/rundown_adc_seq.sv
`timescale 1ns/1ps
module rundown_adc_seq
    import wrd_pkg::*;
#(
    parameter int CODE_W      = DEF_CODE_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int LOST_W      = DEF_LOST_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              peak_ok,
    input  logic              cmp_above,
    output logic              hold_isolate,
    output logic              dischg_on,
    output logic              count_en,
    output logic              busy,
    output logic [CODE_W-1:0] code,
    output logic              overflow,
    output logic              code_valid,
    output logic [LOST_W-1:0] lost_count
);
    localparam int CNT_W = count_width(CODE_W, SYNC_STAGES);

    strobe_t          st;
    logic             cmp_s;
    logic             cnt_clear;
    logic             lost_hit;
    logic [CNT_W-1:0] cnt;

    wrd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (cmp_above),
        .q   (cmp_s)
    );

    wrd_runcounter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .en    (st.count),
        .cnt   (cnt)
    );

    wrd_fsm #(
        .CODE_W      (CODE_W),
        .SYNC_STAGES (SYNC_STAGES),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .peak       (peak_ok),
        .cmp_s      (cmp_s),
        .cnt        (cnt),
        .st         (st),
        .cnt_clear  (cnt_clear),
        .lost_hit   (lost_hit),
        .code       (code),
        .ovf        (overflow),
        .code_valid (code_valid)
    );

    wrd_lost #(.W(LOST_W)) u_lost (
        .clk   (clk),
        .rst   (rst),
        .hit   (lost_hit),
        .total (lost_count)
    );

    assign hold_isolate = st.isolate;
    assign dischg_on    = st.discharge;
    assign count_en     = st.count;
    assign busy         = st.busy;

    assert_dead_time_R7: assert property (@(posedge clk) disable iff (rst)
        busy && peak_ok && !code_valid |=> busy || code_valid);
endmodule

// File: tb/tb_rundown_adc_seq.sv
`timescale 1ns/1ps
module tb_rundown_adc_seq;
    localparam int CODE_W = 13;
    localparam int LOST_W = 8;
    localparam int FULL   = 8191;
    localparam int LTOP   = 255;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic peak_ok = 1'b0;
    logic cmp_above;
    logic hold_isolate, dischg_on, count_en, busy, overflow, code_valid;
    logic [CODE_W-1:0] code;
    logic [LOST_W-1:0] lost_count;

    int amp = 0;
    int kdis = 0;
    logic kclr = 1'b0;
    int n_tests = 0;
    int n_fail = 0;
    int exp_lost = 0;

    always #2.5 clk = ~clk;

    rundown_adc_seq dut (
        .clk(clk), .rst(rst), .peak_ok(peak_ok), .cmp_above(cmp_above),
        .hold_isolate(hold_isolate), .dischg_on(dischg_on), .count_en(count_en),
        .busy(busy), .code(code), .overflow(overflow), .code_valid(code_valid),
        .lost_count(lost_count)
    );

    // Behavioural ramp: capacitor reaches baseline after amp discharge edges
    always @(posedge clk) begin
        if (kclr)           kdis <= 0;
        else if (dischg_on) kdis <= kdis + 1;
    end
    assign cmp_above = (kdis < amp);

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R1", "strobes in reset", {hold_isolate, dischg_on, count_en, busy}, 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "strobes after reset", {hold_isolate, dischg_on, count_en, busy, code_valid, overflow}, 0);
        check_eq("R1", "code after reset", code, 0);
        check_eq("R1", "lost after reset", lost_count, 0);
    endtask

    // One conversion of amplitude a; peak held for peak_len cycles from the
    // start, plus mid single-cycle pulses from busy cycle 10 on.
    task automatic t_convert(input int a, input int peak_len, input int mid);
        int dis_n = 0, busy_n = 0, hold_n = 0, i = 0;
        int exp_code, exp_ovf;
        logic lockstep = 1'b1;
        exp_code = (a > FULL) ? FULL : a;
        exp_ovf  = (a > FULL) ? 1 : 0;
        @(negedge clk);
        amp = a; kclr = 1'b1;
        @(negedge clk);
        kclr = 1'b0;
        @(negedge clk);
        peak_ok = 1'b1;
        @(negedge clk);
        check_eq("R2", "strobes rise together", {hold_isolate, dischg_on, count_en, busy}, 4'hF);
        i = 1;
        while (busy && i < 20000) begin
            busy_n++;
            if (dischg_on) dis_n++;
            if (hold_isolate) hold_n++;
            if (dischg_on != count_en) lockstep = 1'b0;
            peak_ok = (i < peak_len) ||
                      (mid > 0 && i >= 10 && i < 10 + 2 * mid && (i % 2) == 0);
            @(negedge clk);
            i++;
        end
        peak_ok = 1'b0;
        exp_lost = exp_lost + (peak_len - 1) + mid;
        if (exp_lost > LTOP) exp_lost = LTOP;
        check_eq("R2", "discharge and count in lockstep", lockstep, 1);
        check_eq("R3", $sformatf("code for amplitude %0d", a), code, exp_code);
        check_eq("R5", $sformatf("overflow for amplitude %0d", a), overflow, exp_ovf);
        check_eq("R4", $sformatf("discharge cycles for amplitude %0d", a), dis_n, exp_code + 3);
        check_eq("R6", "hold cycles", hold_n, exp_code + 4);
        check_eq("R6", "busy cycles", busy_n, exp_code + 5);
        check_eq("R6", "code_valid as busy falls", code_valid, 1);
        check_eq("R7", "lost count", lost_count, exp_lost);
        @(negedge clk);
        check_eq("R9", "code_valid one cycle", code_valid, 0);
        check_eq("R9", "code holds", code, exp_code);
        check_eq("R9", "overflow holds", overflow, exp_ovf);
    endtask

    initial begin
        t_reset();
        t_convert(0, 1, 0);       // R3 R4 zero amplitude, blanking window
        t_convert(1, 1, 0);
        t_convert(37, 1, 0);
        t_convert(50, 1, 3);      // R7 stray pulses during dead time
        t_convert(400, 300, 0);   // R8 lost counter saturates
        t_convert(9000, 1, 0);    // R5 beyond full scale
        t_convert(FULL, 1, 0);    // R5 exactly full scale, no overflow
        t_convert(9000, 1, 0);
        t_convert(5, 1, 0);       // R9 overflow cleared by normal result
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule